// File: doc/BRIEF.md
# Diagnostic shadow pipeline register

This block is a W-bit pipeline register placed on a parallel data path, paired with a shadow register of the same width that serves serial scan testing and the writing of control-store words. The pipeline register and the shadow register each have their own rising-edge clock. The two clocks are independent, so both registers can update in the same cycle.

A mode input and the serial input together choose what each register does. With mode low, the shadow register shifts one place toward its top bit on every shadow-clock edge, and the pipeline register loads from the data port. With mode high, the serial input chooses between two shadow actions: capturing the pipeline output, or holding while its contents drive the data port outward. In both cases the pipeline register loads from the shadow register. The serial output can be wired to the serial input of a neighbouring instance, so that several instances form one scan loop.

The bidirectional data port is split into an input value, an output value and an output enable. The tri-state pipeline output is split into a value and an enable.

Top module: `diag_shadow_reg`

## Requirements
- R1: Reset is synchronous and active high. A pipeline-clock edge with rst high clears the pipeline register (y_out) to 0, and a shadow-clock edge with rst high clears the shadow register (d_out) to 0. Each register clears only on an edge of its own clock.
- R2: With mode=0, a shadow-clock edge shifts the shadow register: bit i takes bit i-1, and bit 0 takes ser_in. The new value is {shadow[W-2:0], ser_in}.
- R3: With mode=0, ser_out equals shadow bit W-1 (d_out[W-1]).
- R4: With mode=0, a pipeline-clock edge loads the pipeline register from d_in.
- R5: With mode=1 and ser_in=0, a shadow-clock edge loads the shadow register from the pipeline register value that was presented on y_out before the edge.
- R6: With mode=1 and ser_in=1, a shadow-clock edge leaves the shadow register unchanged. d_out always presents the shadow register.
- R7: With mode=1, a pipeline-clock edge loads the pipeline register from the shadow register value held before the edge.
- R8: With mode=1, ser_out follows ser_in combinationally.
- R9: d_oe is 1 only when mode=1 and ser_in=1, and 0 otherwise. y_out always presents the pipeline register, and y_en is the inverse of y_hiz.
- R10: When both clocks rise in the same cycle, each register takes the result that its own rule gives from the pre-edge values, with no interference between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pipeline register clock, rising edge |
| sclk | input | 1 | Shadow register clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, applied per clock |
| mode | input | 1 | Operation select |
| ser_in | input | 1 | Serial data input and sub-mode select when mode=1 |
| d_in | input | W | Data port input value |
| y_hiz | input | 1 | High selects high impedance on the pipeline output |
| d_out | output | W | Data port output value (shadow contents) |
| d_oe | output | 1 | Data port drives outward when 1 |
| ser_out | output | 1 | Serial data output |
| y_out | output | W | Pipeline register value |
| y_en | output | 1 | Pipeline output enable |

## Verification
The hardest situation to reach is a single cycle in which both clocks rise together. In that cycle the shadow register captures or shifts from the pipeline value that is being replaced, while the pipeline register loads either from the data port or from the shadow value that is itself changing. The bench gates one base clock into both register clocks and sweeps every combination of mode, serial input and clock enables against a running model of both registers. In this way every op pairing also occurs with both edges in the same cycle, and each result is compared with the value derived from the pre-edge state.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [1:0] {
    SH_SHIFT   = 2'd0,
    SH_CAPTURE = 2'd1,
    SH_HOLD    = 2'd2
  } sh_op_t;

  typedef enum logic {
    PS_DATA   = 1'b0,
    PS_SHADOW = 1'b1
  } pipe_src_t;
endpackage

// File: rtl/diag_mode_decode.sv
module diag_mode_decode
  import diag_pkg::*;
(
  input  logic      mode,
  input  logic      ser_in,
  output sh_op_t    sh_op,
  output pipe_src_t pipe_src,
  output logic      port_drive,
  output logic      so_bypass
);
  always_comb begin
    if (!mode) begin
      sh_op      = SH_SHIFT;
      pipe_src   = PS_DATA;
      port_drive = 1'b0;
      so_bypass  = 1'b0;
    end else begin
      sh_op      = ser_in ? SH_HOLD : SH_CAPTURE;
      pipe_src   = PS_SHADOW;
      port_drive = ser_in;
      so_bypass  = 1'b1;
    end
  end
endmodule

// File: rtl/diag_shadow.sv
module diag_shadow
  import diag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  sh_op_t       op,
  input  logic         ser_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic shift_src;
    if (i == 0) begin : g_lsb
      assign shift_src = ser_in;
    end else begin : g_up
      assign shift_src = q[i-1];
    end
    always_comb begin
      case (op)
        SH_SHIFT:   nxt[i] = shift_src;
        SH_CAPTURE: nxt[i] = y_in[i];
        default:    nxt[i] = q[i];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R2
  shift_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && op == SH_SHIFT) |=> q == {$past(q[W-2:0]), $past(ser_in)});
  // R5
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && op == SH_CAPTURE) |=> q == $past(y_in));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && op == SH_HOLD) |=> $stable(q));
endmodule

// File: rtl/diag_pipe.sv
module diag_pipe
  import diag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  pipe_src_t    src,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] shadow,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                    q <= '0;
    else if (src == PS_SHADOW)  q <= shadow;
    else                        q <= d_in;
  end

  // R4
  data_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && src == PS_DATA) |=> q == $past(d_in));
  // R7
  shadow_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && src == PS_SHADOW) |=> q == $past(shadow));
endmodule

// File: rtl/diag_shadow_reg.sv
module diag_shadow_reg
  import diag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         pclk,
  input  logic         sclk,
  input  logic         rst,
  input  logic         mode,
  input  logic         ser_in,
  input  logic [W-1:0] d_in,
  input  logic         y_hiz,
  output logic [W-1:0] d_out,
  output logic         d_oe,
  output logic         ser_out,
  output logic [W-1:0] y_out,
  output logic         y_en
);
  sh_op_t       sh_op;
  pipe_src_t    pipe_src;
  logic         so_bypass;
  logic [W-1:0] shadow_q;
  logic [W-1:0] pipe_q;

  diag_mode_decode u_dec (
    .mode       (mode),
    .ser_in     (ser_in),
    .sh_op      (sh_op),
    .pipe_src   (pipe_src),
    .port_drive (d_oe),
    .so_bypass  (so_bypass)
  );

  diag_shadow #(.W(W)) u_shadow (
    .clk    (sclk),
    .rst    (rst),
    .op     (sh_op),
    .ser_in (ser_in),
    .y_in   (pipe_q),
    .q      (shadow_q)
  );

  diag_pipe #(.W(W)) u_pipe (
    .clk    (pclk),
    .rst    (rst),
    .src    (pipe_src),
    .d_in   (d_in),
    .shadow (shadow_q),
    .q      (pipe_q)
  );

  assign d_out   = shadow_q;
  assign y_out   = pipe_q;
  assign y_en    = ~y_hiz;
  assign ser_out = so_bypass ? ser_in : shadow_q[W-1];

  // R8
  drive_bypass_chk: assert property (@(posedge sclk) disable iff (rst)
    d_oe |-> ser_out);
  // R3
  so_msb_chk: assert property (@(posedge sclk) disable iff (rst)
    !mode |-> ser_out == d_out[W-1]);
endmodule

// File: tb/diag_shadow_reg_bench.sv
module diag_shadow_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic pen = 1'b0, sen = 1'b0;
  logic rst = 1'b1, mode = 1'b0, ser_in = 1'b0, y_hiz = 1'b0;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] d_out, y_out;
  logic d_oe, ser_out, y_en;
  logic pclk, sclk;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] mp = '0, ms = '0;

  always #4 clk = ~clk;
  assign pclk = clk & pen;
  assign sclk = clk & sen;

  diag_shadow_reg #(.W(W)) u_diag_shadow_reg (
    .pclk(pclk), .sclk(sclk), .rst(rst), .mode(mode), .ser_in(ser_in),
    .d_in(d_in), .y_hiz(y_hiz), .d_out(d_out), .d_oe(d_oe),
    .ser_out(ser_out), .y_out(y_out), .y_en(y_en)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic p, logic s);
    pen = p;
    sen = s;
    @(posedge clk);
    @(negedge clk);
    pen = 1'b0;
    sen = 1'b0;
    #1;
  endtask

  task automatic model(logic p, logic s);
    logic [W-1:0] np, ns;
    np = mp;
    ns = ms;
    if (p) np = rst ? '0 : (mode ? ms : d_in);
    if (s) begin
      if (rst)          ns = '0;
      else if (!mode)   ns = {ms[W-2:0], ser_in};
      else if (!ser_in) ns = mp;
    end
    mp = np;
    ms = ns;
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1;
    step(1'b1, 1'b1);
    model(1'b1, 1'b1);
    check("R1 pipe reset", y_out, '0);
    check("R1 shadow reset", d_out, '0);
    rst = 1'b0;

    for (int i = 0; i < 2048; i++) begin
      logic p, s;
      string tg;
      mode   = i[0];
      ser_in = i[1];
      p      = i[2];
      s      = i[3];
      y_hiz  = i[4];
      d_in   = W'((i * 37 + 5 + (i >> 5) * 11) & 8'hFF);
      #1;
      check("R9 d_oe", {7'd0, d_oe}, {7'd0, mode & ser_in});
      check("R9 y_en", {7'd0, y_en}, {7'd0, ~y_hiz});
      if (mode) check("R8 ser_out", {7'd0, ser_out}, {7'd0, ser_in});
      else      check("R3 ser_out", {7'd0, ser_out}, {7'd0, ms[W-1]});
      model(p, s);
      step(p, s);
      tg = mode ? "R7 pipe load" : "R4 pipe load";
      if (p && s) tg = mode ? "R10 R7 same-cycle pipe" : "R10 R4 same-cycle pipe";
      check(tg, y_out, mp);
      tg = !mode ? "R2 shadow shift" : (ser_in ? "R6 shadow hold" : "R5 shadow capture");
      if (p && s) tg = {"R10 ", tg};
      check(tg, d_out, ms);
    end

    // make both registers nonzero, then reset on one clock at a time
    mode = 1'b0;
    d_in = 8'hA5;
    ser_in = 1'b1;
    model(1'b1, 1'b1);
    step(1'b1, 1'b1);
    check("R4 preload", y_out, mp);
    check("R2 preload", d_out, ms);
    rst = 1'b1;
    model(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R1 pipe-only reset", y_out, 8'h00);
    check("R1 shadow untouched", d_out, ms);
    model(1'b0, 1'b1);
    step(1'b0, 1'b1);
    check("R1 shadow reset", d_out, 8'h00);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule